// File: doc/BRIEF.md
# Interleaved Dual Spreading Code Generator

This block produces a single spreading chip stream by alternating chips from two component codes, a medium-length code (M) and a long code (L). Both codes come from identical Galois shift-register generators that share one feedback-tap setting. Each generator has its own seed and its own short-cycle length. After the configured number of chips it reloads its seed, so each code repeats with its own period. In the interleaved mode the combined stream runs at the chip-enable rate and each component code advances at half that rate. With a 1.023 MHz enable, each code runs at 511.5 kHz.

A mode input can also select one component code alone at the full enable rate. A synchronisation strobe reloads both seeds and sends the stream back to an M slot. A slot flag tells a downstream correlator which code owns the chip now on the output. A one-clock epoch strobe marks the first chip of each new code period.

Top module: `tdm_code_gen`

## Requirements
- R1: While reset is asserted and until the first synchronisation strobe, `chip_o`, `slot_o`, `m_epoch_o` and `l_epoch_o` are all 0. This holds in the M-only mode.
- R2: One clock after `sync_i` is high, both generators hold their seeds and their chip counts are zero. `chip_o` then shows bit 0 of the owning code's seed, and `slot_o` is 0 in the interleaved mode.
- R3: Each generator emits bit 0 of its state. On an advance the next state is the state shifted right by one with 0 entering at the top, XORed with `taps_i` when the emitted bit was 1.
- R4: In the interleaved mode (`mode_i` = 2'b10 or 2'b11) the chips come out in the order M0, L0, M1, L1 and so on. Each enable advances exactly one generator: the M generator when the slot is 0 and the L generator when the slot is 1.
- R5: In the interleaved mode `slot_o` is 0 while an M chip is shown and 1 while an L chip is shown. It toggles on every chip enable.
- R6: A generator that has advanced `len` times since it was seeded reloads its seed on that advance and restarts its count. Its chip sequence therefore repeats every `len` chips.
- R7: `m_epoch_o` or `l_epoch_o` is high for exactly one clock. That clock follows the enable on which the matching generator reloaded, so the strobe coincides with chip 0 of the new period.
- R8: In the M-only mode (`mode_i` = 2'b00) every enable advances the M generator. `slot_o` stays 0 and the L generator does not move.
- R9: In the L-only mode (`mode_i` = 2'b01) every enable advances the L generator. `slot_o` stays 1 and the M generator does not move.
- R10: In a clock with neither `chip_en_i` nor `sync_i` set, no generator state, count, slot or output changes, and no epoch strobe is raised.
- R11: `sync_i` takes priority over `chip_en_i` in the same clock and never raises an epoch strobe.
- R12: A length input of 0 selects the default period: 10230 chips for M and 767250 chips for L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chip_en_i | input | 1 | One-clock pulse per output chip |
| sync_i | input | 1 | Reloads both seeds and returns the slot to M |
| mode_i | input | 2 | 00 M only, 01 L only, 1x interleaved |
| taps_i | input | 27 | Galois feedback tap mask shared by both generators |
| m_seed_i | input | 27 | M generator seed |
| l_seed_i | input | 27 | L generator seed |
| m_len_i | input | 20 | M period in chips, 0 selects the default |
| l_len_i | input | 20 | L period in chips, 0 selects the default |
| chip_o | output | 1 | Current output chip |
| slot_o | output | 1 | 0 for an M chip, 1 for an L chip |
| m_epoch_o | output | 1 | One-clock strobe at chip 0 of each new M period |
| l_epoch_o | output | 1 | One-clock strobe at chip 0 of each new L period |

## Verification
Every result is due one clock after the edge that captures its stimulus. After an enable, the chip and slot change at once, and the epoch strobe appears in that same following clock. After `sync_i`, the seed chip and slot 0 appear one clock later. After reset is released, the internal two-flop synchroniser holds the block idle for two more edges, so no stimulus is applied in that window. Inputs are driven on the falling edge. A behavioural model updates on the rising edge, and all outputs are compared against it on the next falling edge, so each check lands exactly one register stage after the stimulus it depends on.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int unsigned LFSR_W    = 27;
  localparam int unsigned CNT_W     = 20;
  localparam int unsigned DEF_M_LEN = 10230;
  localparam int unsigned DEF_L_LEN = 767250;
  localparam int unsigned NUM_CODES = 2;

  typedef enum logic [1:0] {
    MODE_MONO_M = 2'b00,
    MODE_MONO_L = 2'b01,
    MODE_TDM    = 2'b10,
    MODE_TDM_B  = 2'b11
  } code_mode_e;
endpackage

// File: rtl/dtc_rst_sync.sv
module dtc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/dtc_lfsr_gen.sv
module dtc_lfsr_gen #(
  parameter int unsigned W       = 27,
  parameter int unsigned CW      = 20,
  parameter int unsigned DEF_LEN = 10230
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_i,
  input  logic          adv_i,
  input  logic [W-1:0]  seed_i,
  input  logic [W-1:0]  taps_i,
  input  logic [CW-1:0] len_i,
  output logic          chip_o,
  output logic          epoch_o
);
  localparam logic [CW-1:0] DEF_LEN_V = CW'(DEF_LEN);

  logic [W-1:0]  state_q, state_d, step_v;
  logic [CW-1:0] cnt_q, cnt_d, len_eff;
  logic [CW:0]   cnt_inc;
  logic          ep_q, ep_d, wrap;

  always_comb begin
    len_eff = (len_i == '0) ? DEF_LEN_V : len_i;
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    wrap    = (cnt_inc >= {1'b0, len_eff});
    step_v  = {1'b0, state_q[W-1:1]} ^ (state_q[0] ? taps_i : '0);
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ep_d    = 1'b0;
    if (sync_i) begin
      state_d = seed_i;
      cnt_d   = '0;
    end else if (adv_i) begin
      if (wrap) begin
        state_d = seed_i;
        cnt_d   = '0;
        ep_d    = 1'b1;
      end else begin
        state_d = step_v;
        cnt_d   = cnt_inc[CW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      cnt_q   <= '0;
      ep_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ep_q    <= ep_d;
    end
  end

  assign chip_o  = state_q[0];
  assign epoch_o = ep_q;

  // R2
  seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> (state_q == $past(seed_i)) && (cnt_q == '0) && !epoch_o);

  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !sync_i && wrap) |=> (cnt_q == '0) && (state_q == $past(seed_i)));

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !sync_i && !wrap) |=> (cnt_q == CW'($past(cnt_q) + 1'b1)));

  // R7
  epoch_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    epoch_o |-> (cnt_q == '0));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !sync_i) |=> $stable(state_q) && $stable(cnt_q) && !epoch_o);
endmodule

// File: rtl/dtc_slot_ctrl.sv
module dtc_slot_ctrl
  import dtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_i,
  input  logic       chip_en_i,
  input  logic [1:0] mode_i,
  output logic [1:0] adv_o,
  output logic       slot_o
);
  code_mode_e mode;
  logic       tdm, slot_q, slot_d;

  always_comb begin
    mode     = code_mode_e'(mode_i);
    tdm      = (mode == MODE_TDM) || (mode == MODE_TDM_B);
    adv_o[0] = chip_en_i && (tdm ? !slot_q : (mode == MODE_MONO_M));
    adv_o[1] = chip_en_i && (tdm ?  slot_q : (mode == MODE_MONO_L));
    slot_d   = slot_q;
    if (sync_i)                slot_d = 1'b0;
    else if (chip_en_i && tdm) slot_d = ~slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= 1'b0;
    else        slot_q <= slot_d;
  end

  assign slot_o = tdm ? slot_q : (mode == MODE_MONO_L);

  // R4
  one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(adv_o));

  // R5
  slot_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en_i && !sync_i && tdm) |=> (slot_q != $past(slot_q)));

  // R11
  sync_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> !slot_q);
endmodule

// File: rtl/tdm_code_gen.sv
module tdm_code_gen
  import dtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en_i,
  input  logic              sync_i,
  input  logic [1:0]        mode_i,
  input  logic [LFSR_W-1:0] taps_i,
  input  logic [LFSR_W-1:0] m_seed_i,
  input  logic [LFSR_W-1:0] l_seed_i,
  input  logic [CNT_W-1:0]  m_len_i,
  input  logic [CNT_W-1:0]  l_len_i,
  output logic              chip_o,
  output logic              slot_o,
  output logic              m_epoch_o,
  output logic              l_epoch_o
);
  logic                    rst_n_int;
  logic [NUM_CODES-1:0]    adv, chip_v, ep_v;
  logic [LFSR_W-1:0]       seed_v [NUM_CODES];
  logic [CNT_W-1:0]        len_v  [NUM_CODES];

  assign seed_v[0] = m_seed_i;
  assign seed_v[1] = l_seed_i;
  assign len_v[0]  = m_len_i;
  assign len_v[1]  = l_len_i;

  dtc_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_int)
  );

  dtc_slot_ctrl u_slot (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .sync_i    (sync_i),
    .chip_en_i (chip_en_i),
    .mode_i    (mode_i),
    .adv_o     (adv),
    .slot_o    (slot_o)
  );

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
    localparam int unsigned LEN_D = (g == 0) ? DEF_M_LEN : DEF_L_LEN;
    dtc_lfsr_gen #(
      .W       (LFSR_W),
      .CW      (CNT_W),
      .DEF_LEN (LEN_D)
    ) u_gen (
      .clk     (clk),
      .rst_n   (rst_n_int),
      .sync_i  (sync_i),
      .adv_i   (adv[g]),
      .seed_i  (seed_v[g]),
      .taps_i  (taps_i),
      .len_i   (len_v[g]),
      .chip_o  (chip_v[g]),
      .epoch_o (ep_v[g])
    );
  end

  assign chip_o    = slot_o ? chip_v[1] : chip_v[0];
  assign m_epoch_o = ep_v[0];
  assign l_epoch_o = ep_v[1];

  // R11
  sync_no_epoch_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    sync_i |=> !m_epoch_o && !l_epoch_o);
endmodule

// File: tb/tdm_code_gen_bench.sv
module tdm_code_gen_bench;
  localparam int PERIOD = 10;
  localparam int W      = 27;
  localparam int CW     = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          chip_en_i = 1'b0;
  logic          sync_i = 1'b0;
  logic [1:0]    mode_i = 2'b00;
  logic [W-1:0]  taps_i = '0;
  logic [W-1:0]  m_seed_i = '0;
  logic [W-1:0]  l_seed_i = '0;
  logic [CW-1:0] m_len_i = '0;
  logic [CW-1:0] l_len_i = '0;
  logic          chip_o, slot_o, m_epoch_o, l_epoch_o;

  int checks = 0;
  int failures = 0;
  string tag = "R1";

  always #(PERIOD/2) clk = ~clk;

  tdm_code_gen u_tdm_code_gen (
    .clk(clk), .rst_n(rst_n), .chip_en_i(chip_en_i), .sync_i(sync_i),
    .mode_i(mode_i), .taps_i(taps_i), .m_seed_i(m_seed_i), .l_seed_i(l_seed_i),
    .m_len_i(m_len_i), .l_len_i(l_len_i), .chip_o(chip_o), .slot_o(slot_o),
    .m_epoch_o(m_epoch_o), .l_epoch_o(l_epoch_o)
  );

  // behavioural reference
  logic [W-1:0] ms = '0, ls = '0;
  int mc = 0, lc = 0;
  bit slot_m = 0, mep = 0, lep = 0;

  function automatic logic [W-1:0] galois(logic [W-1:0] s, logic [W-1:0] t);
    logic [W-1:0] r;
    r = s >> 1;
    if (s[0]) r = r ^ t;
    return r;
  endfunction

  always @(posedge clk) begin
    int ml, ll;
    bit am, al, tdm;
    ml  = (m_len_i == 0) ? 10230  : int'(m_len_i);
    ll  = (l_len_i == 0) ? 767250 : int'(l_len_i);
    tdm = mode_i[1];
    if (!rst_n) begin
      ms = '0; ls = '0; mc = 0; lc = 0; slot_m = 0; mep = 0; lep = 0;
    end else if (sync_i) begin
      ms = m_seed_i; ls = l_seed_i; mc = 0; lc = 0; slot_m = 0; mep = 0; lep = 0;
    end else begin
      mep = 0; lep = 0;
      if (chip_en_i) begin
        am = tdm ? !slot_m : (mode_i == 2'b00);
        al = tdm ?  slot_m : (mode_i == 2'b01);
        if (am) begin
          if (mc + 1 >= ml) begin ms = m_seed_i; mc = 0; mep = 1; end
          else begin ms = galois(ms, taps_i); mc++; end
        end
        if (al) begin
          if (lc + 1 >= ll) begin ls = l_seed_i; lc = 0; lep = 1; end
          else begin ls = galois(ls, taps_i); lc++; end
        end
        if (tdm) slot_m = !slot_m;
      end
    end
  end

  task automatic compare();
    bit es, ec;
    es = mode_i[1] ? slot_m : (mode_i == 2'b01);
    ec = es ? ls[0] : ms[0];
    checks++;
    if ({chip_o, slot_o, m_epoch_o, l_epoch_o} !== {ec, es, mep, lep}) begin
      failures++;
      $display("FAIL %s chip/slot/mep/lep actual=%b%b%b%b expected=%b%b%b%b",
               tag, chip_o, slot_o, m_epoch_o, l_epoch_o, ec, es, mep, lep);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic do_sync();
    sync_i = 1'b1;
    cycle();
    sync_i = 1'b0;
  endtask

  task automatic check_bit(string t, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", t, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    logic mq[$];
    int m_ep_seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1 reset";
    repeat (4) cycle();
    check_bit("R1 chip", chip_o, 1'b0);
    check_bit("R1 slot", slot_o, 1'b0);
    check_bit("R1 epochs", m_epoch_o | l_epoch_o, 1'b0);

    taps_i   = 27'h4000027;
    m_seed_i = 27'h1ABCDE5;
    l_seed_i = 27'h0F0F0F2;
    m_len_i  = 20'd7;
    l_len_i  = 20'd21;
    mode_i   = 2'b10;
    tag = "R2 sync";
    do_sync();
    check_bit("R2 seed chip", chip_o, m_seed_i[0]);
    check_bit("R2 slot", slot_o, 1'b0);

    tag = "R3 R4 R5 R6 R7 interleave";
    chip_en_i = 1'b1;
    for (int i = 0; i < 200; i++) begin
      if (slot_o == 1'b0) mq.push_back(chip_o);
      cycle();
    end
    for (int i = 0; i < 7; i++)
      check_bit("R6 M period repeat", mq[i + 7], mq[i]);

    tag = "R10 sparse enable";
    for (int i = 0; i < 300; i++) begin
      chip_en_i = ($urandom % 3) == 0;
      cycle();
    end
    chip_en_i = 1'b0;
    repeat (3) cycle();

    tag = "R11 sync with enable";
    mode_i = 2'b11;
    chip_en_i = 1'b1;
    do_sync();
    check_bit("R11 slot after sync", slot_o, 1'b0);
    check_bit("R11 no epoch", m_epoch_o | l_epoch_o, 1'b0);
    check_bit("R11 seed chip", chip_o, m_seed_i[0]);
    repeat (60) cycle();

    tag = "R8 M only";
    mode_i = 2'b00;
    m_len_i = 20'd5;
    do_sync();
    for (int i = 0; i < 100; i++) begin
      cycle();
      check_bit("R8 slot low", slot_o, 1'b0);
    end

    tag = "R9 L only";
    mode_i = 2'b01;
    l_len_i = 20'd9;
    do_sync();
    for (int i = 0; i < 100; i++) begin
      cycle();
      check_bit("R9 slot high", slot_o, 1'b1);
    end

    tag = "R12 default M length";
    mode_i = 2'b00;
    m_len_i = '0;
    do_sync();
    m_ep_seen = 0;
    for (int i = 1; i <= 10235; i++) begin
      cycle();
      if (m_epoch_o) begin
        m_ep_seen++;
        check_bit("R12 epoch at chip 10230", (i == 10230), 1'b1);
      end
    end
    check_bit("R12 one epoch", (m_ep_seen == 1), 1'b1);

    chip_en_i = 1'b0;
    repeat (2) cycle();
    summary();
  end
endmodule